// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block keeps a 256-bit device secret as eight 32-bit words and serves it on a small 32-bit register bus. Boot firmware may fetch each word exactly once after reset. A second fetch of the same word is refused. Every fetch is also refused while the system-mode input reports that the application has taken over. The same window holds three identification words (two name words and a version), and these can be read at any time.

The secret, the name words and the version are elaboration-time parameters. The block has no writable location. Every write is refused and changes nothing.

Each accepted request, legal or not, gets exactly one response one cycle later. A refused or malformed request returns zero data and raises a one-cycle error strobe together with the response. The per-word consumed marks clear only on reset.

Top module: `secret_vault`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `rsp_valid` and `rsp_err` are 0. Reset clears every consumed mark.
- R2: A legal word read at offset 0x00 returns `NAME_LO`, at 0x04 returns `NAME_HI`, and at 0x08 returns `VERSION`. None of these reads raises an error, and they work in either system mode.
- R3: The first legal word read of offset 0x40 + 4·i (i = 0..7) while `app_mode` is 0 returns bits [32·i+31 : 32·i] of `SECRET` with `rsp_err` = 0. That word is then marked consumed.
- R4: A later read of a consumed word returns 0 with `rsp_err` = 1. Reads of words that are not consumed are unaffected.
- R5: While `app_mode` is 1, every secret read returns 0 with `rsp_err` = 1 and does not consume the word.
- R6: Every write (`req_write` = 1) is refused with `rsp_err` = 1 and zero data, and leaves the secret unchanged. A write to a secret word does not consume it.
- R7: A legal access has `req_size` = 2 (4 bytes) and `req_addr[1:0]` = 0. Any other size or alignment is refused with zero data and `rsp_err` = 1, and consumes nothing.
- R8: A legal read of an offset outside the identification words and the secret range returns 0 with `rsp_err` = 1.
- R9: A request sampled with `req_valid` = 1 on a rising edge gives `rsp_valid` = 1 for exactly the following cycle. Back-to-back requests are accepted every cycle. `rsp_err` is never 1 without `rsp_valid`, and data is 0 whenever `rsp_err` is 1.
- R10: Consumed marks never clear except through reset. After a new reset, every word can be read once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_mode | input | 1 | 1 while the system runs the application |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | 2 | Access size: 0 = byte, 1 = half, 2 = word |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_data | output | 32 | Read data, 0 on any refusal |
| rsp_err | output | 1 | One-cycle strobe for a refused or bad access |

## Verification
The reads run in three orders: first reads scattered across the range, including both end words; back-to-back reads issued on every cycle; and repeated reads of the same words. Together these separate index decoding from consumed-mark tracking. Secret reads in application mode are each followed by the same read in firmware mode. Writes, byte and halfword sizes, and misaligned offsets are each followed by a legal read of the same word. Both checks show that a refused access leaves the word unconsumed. A mid-run reset followed by a full sweep of all eight words separates reset clearing from the sticky marks.

// File: rtl/vault_pkg.sv
package vault_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_IDENT  = 2'd1,
    ACC_SECRET = 2'd2,
    ACC_REFUSE = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/vault_decode.sv
module vault_decode
  import vault_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int N_WORDS   = 8,
  parameter int SEC_BASE  = 'h40,
  localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              app_mode,
  input  logic [N_WORDS-1:0] used,
  output acc_kind_t         kind,
  output logic [IDX_W-1:0]  word_idx,
  output logic [1:0]        id_sel
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(SEC_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(SEC_BASE + 4 * N_WORDS);

  logic              aligned;
  logic              in_secret;
  logic [ADDR_W-1:0] offset;

  assign aligned   = (req_size == 2'd2) && (req_addr[1:0] == 2'b00);
  assign in_secret = (req_addr >= LO) && (req_addr < HI);
  assign offset    = req_addr - LO;
  assign word_idx  = offset[IDX_W+1:2];

  always_comb begin
    id_sel = 2'd3;
    if (req_addr == ADDR_W'(0)) id_sel = 2'd0;
    else if (req_addr == ADDR_W'(4)) id_sel = 2'd1;
    else if (req_addr == ADDR_W'(8)) id_sel = 2'd2;
  end

  always_comb begin
    if (!req_valid)                  kind = ACC_IDLE;
    else if (req_write || !aligned)  kind = ACC_REFUSE;
    else if (in_secret)              kind = (app_mode || used[word_idx]) ? ACC_REFUSE : ACC_SECRET;
    else if (id_sel != 2'd3)         kind = ACC_IDENT;
    else                             kind = ACC_REFUSE;
  end
endmodule

// File: rtl/vault_seal_flags.sv
module vault_seal_flags #(
  parameter int N_WORDS = 8,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               app_mode,
  input  logic               consume,
  input  logic [IDX_W-1:0]   idx,
  output logic [N_WORDS-1:0] used
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst) used[g] <= 1'b0;
      else if (consume && (idx == IDX_W'(g))) used[g] <= 1'b1;
    end
  end

  // Marks only ever set between resets
  assert_marks_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ((used & $past(used)) == $past(used)));

  // Nothing is consumed by a request taken in application mode
  assert_no_consume_in_app_R5: assert property (@(posedge clk) disable iff (rst)
    $past(app_mode) |-> (used == $past(used)));
endmodule

// File: rtl/vault_resp.sv
module vault_resp
  import vault_pkg::*;
#(
  parameter int N_WORDS                    = 8,
  parameter logic [N_WORDS*WORD_W-1:0] SECRET = '0,
  parameter logic [WORD_W-1:0] NAME_LO     = '0,
  parameter logic [WORD_W-1:0] NAME_HI     = '0,
  parameter logic [WORD_W-1:0] VERSION     = '0,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [1:0]        id_sel,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    assign words[g] = SECRET[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (kind != ACC_IDLE);
      rsp_err   <= (kind == ACC_REFUSE);
      case (kind)
        ACC_SECRET: rsp_data <= words[word_idx];
        ACC_IDENT: begin
          case (id_sel)
            2'd0:    rsp_data <= NAME_LO;
            2'd1:    rsp_data <= NAME_HI;
            2'd2:    rsp_data <= VERSION;
            default: rsp_data <= '0;
          endcase
        end
        default: rsp_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/secret_vault.sv
module secret_vault
  import vault_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int N_WORDS  = 8,
  parameter int SEC_BASE = 'h40,
  parameter logic [N_WORDS*32-1:0] SECRET =
    256'h7E6D5C4B_6F5E4D3C_5A4B3C2D_4B3A2918_3C2B1A09_2D1C0BFA_1E0DFCEB_0FFEEDDC,
  parameter logic [31:0] NAME_LO = 32'h7661_756C,
  parameter logic [31:0] NAME_HI = 32'h7365_616C,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              app_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_err
);
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  acc_kind_t          kind;
  logic [IDX_W-1:0]   word_idx;
  logic [1:0]         id_sel;
  logic [N_WORDS-1:0] used;

  vault_decode #(
    .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .SEC_BASE(SEC_BASE)
  ) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .app_mode(app_mode), .used(used),
    .kind(kind), .word_idx(word_idx), .id_sel(id_sel)
  );

  vault_seal_flags #(.N_WORDS(N_WORDS)) u_flags (
    .clk(clk), .rst(rst), .app_mode(app_mode),
    .consume(kind == ACC_SECRET), .idx(word_idx), .used(used)
  );

  vault_resp #(
    .N_WORDS(N_WORDS), .SECRET(SECRET),
    .NAME_LO(NAME_LO), .NAME_HI(NAME_HI), .VERSION(VERSION)
  ) u_resp (
    .clk(clk), .rst(rst), .kind(kind), .word_idx(word_idx), .id_sel(id_sel),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_err_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
  assert_refusal_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_data == 32'h0));
  assert_write_refused_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> rsp_err);
  assert_bad_size_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_size != 2'd2)) |=> rsp_err);
endmodule

// File: tb/secret_vault_tb.sv
module secret_vault_tb;
  localparam logic [255:0] SEC =
    256'hA1B2C3D4_11223344_DEADBEEF_0BADF00D_CAFEBABE_55AA55AA_12345678_89ABCDEF;
  localparam logic [31:0] NM_LO = 32'h6B65_7930;
  localparam logic [31:0] NM_HI = 32'h7374_6F72;
  localparam logic [31:0] VER   = 32'h0000_0003;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic app_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [7:0] req_addr = 8'h0;
  logic [1:0] req_size = 2'd2;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic rsp_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  secret_vault #(
    .SECRET(SEC), .NAME_LO(NM_LO), .NAME_HI(NM_HI), .VERSION(VER)
  ) u_dut (
    .clk(clk), .rst(rst), .app_mode(app_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  // Behavioural reference model
  bit          m_used [8];
  logic        e_valid = 1'b0;
  logic        e_err   = 1'b0;
  logic [31:0] e_data  = 32'h0;
  string       e_tag   = "R1";
  bit          compare_on = 1'b0;

  function automatic logic [31:0] sec_word(int i);
    return SEC[i*32 +: 32];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_err = 0; e_data = 0; e_tag = "R1";
      foreach (m_used[k]) m_used[k] = 0;
    end else if (!req_valid) begin
      e_valid = 0; e_err = 0; e_data = 0; e_tag = "R9";
    end else begin
      int a;
      a = int'(req_addr);
      e_valid = 1; e_err = 1; e_data = 0;
      if (req_write) e_tag = "R6";
      else if (req_size != 2'd2 || (a % 4) != 0) e_tag = "R7";
      else if (a >= 'h40 && a < 'h60) begin
        int i;
        i = (a - 'h40) / 4;
        if (app_mode) e_tag = "R5";
        else if (m_used[i]) e_tag = "R4";
        else begin
          e_err = 0; e_data = sec_word(i); m_used[i] = 1; e_tag = "R3";
        end
      end else if (a == 0) begin e_err = 0; e_data = NM_LO; e_tag = "R2"; end
      else if (a == 4) begin e_err = 0; e_data = NM_HI; e_tag = "R2"; end
      else if (a == 8) begin e_err = 0; e_data = VER; e_tag = "R2"; end
      else e_tag = "R8";
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      n_tests++;
      if (rsp_valid !== e_valid || rsp_err !== e_err || rsp_data !== e_data) begin
        n_fail++;
        $display("FAIL %s model: got v=%b e=%b d=%h exp v=%b e=%b d=%h",
                 e_tag, rsp_valid, rsp_err, rsp_data, e_valid, e_err, e_data);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] exp_d, logic exp_e);
    n_tests++;
    if (rsp_valid !== 1'b1 || rsp_err !== exp_e || rsp_data !== exp_d) begin
      n_fail++;
      $display("FAIL %s: got v=%b e=%b d=%h exp v=1 e=%b d=%h",
               tag, rsp_valid, rsp_err, rsp_data, exp_e, exp_d);
    end
  endtask

  // One request, one idle cycle; checks the response one cycle later
  task automatic xfer(bit wr, logic [7:0] addr, logic [1:0] size,
                      logic [31:0] exp_d, logic exp_e, string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_size = size;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'd2;
    chk(tag, exp_d, exp_e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare_on = 0; rst = 1; req_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got v=%b e=%b exp v=0 e=0", rsp_valid, rsp_err);
    end
    compare_on = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp end of stimulus");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R2 identification, also under app mode
    xfer(0, 8'h00, 2'd2, NM_LO, 0, "R2 name lo");
    xfer(0, 8'h04, 2'd2, NM_HI, 0, "R2 name hi");
    app_mode = 1;
    xfer(0, 8'h08, 2'd2, VER, 0, "R2 version app");
    // R5 refused in app mode, not consumed
    xfer(0, 8'h44, 2'd2, 32'h0, 1, "R5 app read");
    app_mode = 0;
    xfer(0, 8'h44, 2'd2, sec_word(1), 0, "R5 not consumed");
    // R3 first reads including both ends
    xfer(0, 8'h4C, 2'd2, sec_word(3), 0, "R3 word3");
    xfer(0, 8'h40, 2'd2, sec_word(0), 0, "R3 word0");
    xfer(0, 8'h5C, 2'd2, sec_word(7), 0, "R3 word7");
    // R4 repeats
    xfer(0, 8'h4C, 2'd2, 32'h0, 1, "R4 word3 again");
    xfer(0, 8'h5C, 2'd2, 32'h0, 1, "R4 word7 again");
    // R6 writes refused, word 2 still fresh
    xfer(1, 8'h48, 2'd2, 32'h0, 1, "R6 write secret");
    xfer(1, 8'h00, 2'd2, 32'h0, 1, "R6 write name");
    xfer(0, 8'h48, 2'd2, sec_word(2), 0, "R6 content kept");
    // R7 bad size / alignment, word 4 still fresh
    xfer(0, 8'h50, 2'd1, 32'h0, 1, "R7 half size");
    xfer(0, 8'h50, 2'd0, 32'h0, 1, "R7 byte size");
    xfer(0, 8'h51, 2'd2, 32'h0, 1, "R7 misaligned");
    xfer(0, 8'h50, 2'd2, sec_word(4), 0, "R7 word4 fresh");
    // R8 unmapped
    xfer(0, 8'h10, 2'd2, 32'h0, 1, "R8 gap");
    xfer(0, 8'h60, 2'd2, 32'h0, 1, "R8 past end");
    xfer(0, 8'h3C, 2'd2, 32'h0, 1, "R8 before start");
    // R9 back-to-back reads of words 5,6 then 5 again, one per cycle
    @(negedge clk);
    req_valid = 1; req_addr = 8'h54;
    @(negedge clk);
    chk("R9 b2b word5", sec_word(5), 0);
    req_addr = 8'h58;
    @(negedge clk);
    chk("R9 b2b word6", sec_word(6), 0);
    req_addr = 8'h54;
    @(negedge clk);
    chk("R9 b2b word5 repeat", 32'h0, 1);
    req_valid = 0;
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 idle: got v=%b exp v=0", rsp_valid);
    end
    // R10 marks persist until reset, then all words readable again
    xfer(0, 8'h40, 2'd2, 32'h0, 1, "R10 still consumed");
    do_reset();
    for (int i = 0; i < 8; i++)
      xfer(0, 8'(8'h40 + 4 * i), 2'd2, sec_word(i), 0, "R10 fresh after reset");
    for (int i = 0; i < 8; i++)
      xfer(0, 8'(8'h40 + 4 * i), 2'd2, 32'h0, 1, "R4 second sweep");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule